// File: doc/BRIEF.md
# Quarter-Hour Chime Melody Sequencer

This block turns a fixed four-voice chime tune into a timed train of tone-gate pulses. An outside time-keeper raises a start request at each quarter hour and says which quarter it is. From then on, every beat tick advances the block by one step through a 22-step pattern of notes and rests. Each note step raises exactly one of four tone gates for a programmable number of clock cycles. The quarter sets how much of the tune is played before the block stops.

The step position is held as a column count inside a row plus a row count. A row is ten steps long, and the third row holds only two steps. The tune is built from four groups of four notes, with a two-beat rest after each of the first three groups. Once the last wanted note has been struck and its gate has closed, the block pulses `done`. Alongside that pulse it raises `full` when the whole tune was played, so that a following hour-strike stage can begin.

Top module: `chime_seq`

## Requirements
- R1: A synchronous active-high `rst` returns the block to idle: all gates low, `busy` low, `done` and `full` low, even in the middle of a melody.
- R2: Gate bits map as tone[0]=C (lowest), tone[1]=F, tone[2]=G, tone[3]=A (highest). The note steps, in order, are F A G C, F G A F, A G F C, C G A F.
- R3: Steps 4-5, 10-11 and 16-17 (counting from 0) are rests. A beat on a rest step raises no gate.
- R4: `quarter` encodes 0 = top of hour (16 notes), 1 = quarter past (4 notes), 2 = half past (8 notes) and 3 = quarter to (12 notes). The block stops after that many notes, and later beats strike nothing.
- R5: A note's gate rises in the cycle after the beat that plays it and stays high for `gate_len` cycles. A `gate_len` of 0 acts as 1.
- R6: At most one gate is high at any time. A new note struck while a gate is still open replaces that gate at once. A rest step leaves an open gate running.
- R7: `done` is a one-cycle pulse in the cycle after the last note's gate closes, so it comes `gate_len`+1 cycles after the final beat. `busy` falls in the same cycle. `full` is high only together with `done`, and only for a top-of-hour melody.
- R8: A start request made while `busy` is high is ignored. The running melody keeps its original length.
- R9: A start request while idle raises `busy` in the next cycle, and the first beat after that plays step 0. Beats while idle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| beat | input | 1 | One-cycle beat tick that advances one step |
| start | input | 1 | Melody start request, taken only when idle |
| quarter | input | 2 | Which quarter hour the start belongs to (R4 encoding) |
| gate_len | input | GW | Gate length in clock cycles (0 acts as 1) |
| tone | output | 4 | One-hot tone gates, bit 0 lowest pitch |
| busy | output | 1 | Melody in progress |
| done | output | 1 | One-cycle end-of-melody pulse |
| full | output | 1 | With `done`: the whole tune was played |

## Verification
The bench plays every quarter length and checks where each one stops. A design with a wrong stop index would strike extra notes or end early, and `done` would arrive at the wrong cycle. Rest beats are watched for stray gates, and gates are timed for exact length, including the zero-length case, where an off-by-one counter would give a pulse of 0 or 2 cycles. A long gate with a short beat gap checks that a new note replaces the old gate instead of adding a second one. A start request made in mid-melody with a different quarter is used to show that a design which reloads its length would run on to the full tune. A reset in mid-melody and beats while idle show that no gate leaks out.

// File: rtl/chime_seq.sv
`timescale 1ns/1ps
module chime_seq #(
  parameter int GW        = 16,
  parameter int ROW_W     = 10,
  parameter int NROWS     = 3,
  parameter int LAST_COLS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          beat,
  input  logic          start,
  input  logic [1:0]    quarter,
  input  logic [GW-1:0] gate_len,
  output logic [3:0]    tone,
  output logic          busy,
  output logic          done,
  output logic          full
);
  localparam int NSTEPS = ROW_W * (NROWS - 1) + LAST_COLS;
  localparam int IW     = $clog2(NSTEPS);
  localparam int CW     = $clog2(ROW_W);
  localparam int RW     = $clog2(NROWS);

  logic [CW-1:0] col;
  logic [RW-1:0] row;
  logic [1:0]    q_r;
  logic          fin;
  logic [GW-1:0] gcnt;
  logic [IW-1:0] idx, last_idx;
  logic [3:0]    step_tone;
  logic [GW-1:0] eff_len;
  logic          strike;

  assign idx     = IW'(row) * IW'(ROW_W) + IW'(col);
  assign eff_len = (gate_len == '0) ? GW'(1) : gate_len;
  assign strike  = busy && beat && !fin;

  always_comb begin
    case (q_r)
      2'd1:    last_idx = IW'(3);
      2'd2:    last_idx = IW'(9);
      2'd3:    last_idx = IW'(15);
      default: last_idx = IW'(21);
    endcase
  end

  // C=0001 F=0010 G=0100 A=1000
  always_comb begin
    case (int'(idx))
      0:  step_tone = 4'b0010;
      1:  step_tone = 4'b1000;
      2:  step_tone = 4'b0100;
      3:  step_tone = 4'b0001;
      6:  step_tone = 4'b0010;
      7:  step_tone = 4'b0100;
      8:  step_tone = 4'b1000;
      9:  step_tone = 4'b0010;
      12: step_tone = 4'b1000;
      13: step_tone = 4'b0100;
      14: step_tone = 4'b0010;
      15: step_tone = 4'b0001;
      18: step_tone = 4'b0001;
      19: step_tone = 4'b0100;
      20: step_tone = 4'b1000;
      21: step_tone = 4'b0010;
      default: step_tone = 4'b0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      fin  <= 1'b0;
      done <= 1'b0;
      full <= 1'b0;
      tone <= '0;
      gcnt <= '0;
      col  <= '0;
      row  <= '0;
      q_r  <= '0;
    end else begin
      done <= 1'b0;
      full <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          fin  <= 1'b0;
          col  <= '0;
          row  <= '0;
          q_r  <= quarter;
        end
      end else begin
        if (strike) begin
          if (idx == last_idx) fin <= 1'b1;
          else if (col == CW'(ROW_W - 1)) begin
            col <= '0;
            row <= row + 1'b1;
          end else col <= col + 1'b1;
        end
        if (fin && gcnt == '0) begin
          busy <= 1'b0;
          fin  <= 1'b0;
          done <= 1'b1;
          full <= (q_r == 2'd0);
        end
      end
      if (strike && step_tone != '0) begin
        tone <= step_tone;
        gcnt <= eff_len;
      end else if (gcnt != '0) begin
        gcnt <= gcnt - 1'b1;
        if (gcnt == GW'(1)) tone <= '0;
      end
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (tone == '0 && !busy && !done && !full));

  assert_pos_bound_R2: assert property (@(posedge clk) disable iff (rst)
    (row == RW'(NROWS - 1)) |-> (col < CW'(LAST_COLS)));

  assert_gate_needs_beat_R3: assert property (@(posedge clk) disable iff (rst)
    (tone != '0 && tone != $past(tone)) |-> $past(beat));

  assert_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tone));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_full_with_done_R7: assert property (@(posedge clk) disable iff (rst)
    full |-> done);

  assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy) && tone == '0));

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(q_r));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (tone == '0));
endmodule

// File: tb/sim_chime_seq.sv
`timescale 1ns/1ps
module sim_chime_seq;
  localparam int GW = 16;
  logic clk = 1'b0;
  logic rst, beat, start;
  logic [1:0] quarter;
  logic [GW-1:0] gate_len;
  logic [3:0] tone;
  logic busy, done, full;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  chime_seq #(.GW(GW)) u0 (
    .clk(clk), .rst(rst), .beat(beat), .start(start), .quarter(quarter),
    .gate_len(gate_len), .tone(tone), .busy(busy), .done(done), .full(full)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic logic [3:0] exp_note(input int pos);
    string seq = "FAGCFGAFAGFCCGAF";
    int g = pos / 6;
    int k = pos % 6;
    if (k >= 4) return 4'b0000;
    case (seq[g*4+k])
      "C": return 4'b0001;
      "F": return 4'b0010;
      "G": return 4'b0100;
      default: return 4'b1000;
    endcase
  endfunction

  function automatic int last_pos(input int q);
    int notes = (q == 0) ? 16 : 4 * q;
    return (notes / 4 - 1) * 6 + 3;
  endfunction

  task automatic play(input int q, input int len, input int gap, input int stray);
    int effl = (len == 0) ? 1 : len;
    int last = last_pos(q);
    logic [3:0] e;
    int dur, seen, fullv;
    quarter = 2'(q); gate_len = GW'(len); start = 1'b1;
    tick();
    start = 1'b0;
    chk(busy == 1'b1, "R9 busy after start", int'(busy), 1);
    for (int pos = 0; pos <= last; pos++) begin
      beat = 1'b1;
      if (pos == stray) begin start = 1'b1; quarter = 2'd0; end
      tick();
      beat = 1'b0; start = 1'b0; quarter = 2'(q);
      e = exp_note(pos);
      if (e != 0) chk(tone == e, "R2 note", int'(tone), int'(e));
      else if (gap > effl) chk(tone == 0, "R3 rest", int'(tone), 0);
      dur = (e != 0 && tone == e) ? 1 : 0;
      if (pos < last) begin
        for (int i = 1; i < gap; i++) begin
          tick();
          if (e != 0 && tone == e && dur == i) dur++;
          if (done) chk(1'b0, "R4 early done", 1, 0);
          if (tone != 0 && (tone & (tone - 4'd1)) != 0) chk(1'b0, "R6 onehot", int'(tone), 0);
        end
        if (e != 0 && gap > effl) chk(dur == effl, "R5 gate length", dur, effl);
      end else begin
        seen = -1; fullv = 0;
        for (int i = 1; i < 80 && seen < 0; i++) begin
          tick();
          if (tone == e && dur == i) dur++;
          if (done) begin seen = i; fullv = int'(full); end
        end
        chk(seen == effl + 1, "R7 done timing", seen, effl + 1);
        chk(fullv == ((q == 0) ? 1 : 0), "R7 full flag", fullv, (q == 0) ? 1 : 0);
        chk(dur == effl, "R5 last gate length", dur, effl);
        chk(busy == 1'b0, "R7 busy after done", int'(busy), 0);
      end
    end
    beat = 1'b1; tick(); beat = 1'b0; tick();
    chk(tone == 0 && !busy, "R4 no note after stop", int'(tone), 0);
    repeat (3) tick();
  endtask

  task automatic t_reset();
    rst = 1'b1; beat = 1'b0; start = 1'b0; quarter = 2'd0; gate_len = '0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk(tone == 0 && !busy && !done && !full, "R1 reset state", int'(tone), 0);
  endtask

  task automatic t_idle_beats();
    for (int i = 0; i < 5; i++) begin
      beat = 1'b1; tick(); beat = 1'b0; tick();
      chk(tone == 0 && !busy, "R9 idle beat ignored", int'(tone), 0);
    end
  endtask

  task automatic t_reset_mid();
    quarter = 2'd0; gate_len = GW'(20); start = 1'b1; tick(); start = 1'b0;
    beat = 1'b1; tick(); beat = 1'b0;
    chk(tone == 4'b0010, "R2 first note", int'(tone), 2);
    rst = 1'b1; tick(); rst = 1'b0;
    chk(tone == 0 && !busy && !done, "R1 reset mid melody", int'(tone), 0);
    beat = 1'b1; tick(); beat = 1'b0; tick();
    chk(tone == 0 && !busy, "R1 idle after reset", int'(tone), 0);
  endtask

  task automatic t_overlap();
    quarter = 2'd1; gate_len = GW'(9); start = 1'b1; tick(); start = 1'b0;
    beat = 1'b1; tick(); beat = 1'b0;
    chk(tone == 4'b0010, "R6 first gate", int'(tone), 2);
    tick(); tick();
    beat = 1'b1; tick(); beat = 1'b0;
    chk(tone == 4'b1000, "R6 gate replaced", int'(tone), 8);
    repeat (20) tick();
    beat = 1'b1; tick(); tick(); beat = 1'b1; tick(); beat = 1'b0;
    chk(tone == 4'b0001, "R6 fourth note", int'(tone), 1);
    repeat (12) tick();
    chk(!busy, "R6 ended", int'(busy), 0);
    repeat (2) tick();
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_idle_beats();
    play(0, 3, 6, -1);
    play(1, 1, 4, -1);
    play(2, 5, 8, -1);
    play(3, 2, 5, -1);
    play(1, 0, 3, -1);
    play(2, 10, 4, -1);
    play(1, 2, 4, 1);
    play(3, 1, 3, 7);
    t_overlap();
    t_reset_mid();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule